// File: doc/BRIEF.md
# Lockable Block Write-Protection Unit

This unit sits beside a byte-addressed memory array's write path. It holds a small protection control word and decides, for each data byte aimed at an array address, whether that byte may be acknowledged and committed. Protection is switched on by an enable bit. A two-bit block selector then chooses how much of the top of a 16 KiB array is read-only: the top quarter, half, three quarters, or all of it.

A lock bit in the same word freezes the control bits permanently once it is set. The control bits live in a retained store, which stands in for non-volatile cells. Address checks use a separate active copy. That copy is refreshed from the store when a new write transaction starts, or when the reload input is pulsed as a soft reset. An update that is accepted mid-transaction therefore never changes the outcome of the transaction already running.

Top module: `wp_unit`

## Requirements
- R1: After `rst_ni` is asserted, the stored and active control bits are all zero, `reg_rdata_o` reads 0x00 and no address is protected.
- R2: While the active enable bit is 0, `prot_o` is 0 for every address, whatever the block-select value.
- R3: With the active enable set, `prot_o` is 1 exactly for these ranges. Block-select 2'b00 protects 0x3000..0x3FFF. 2'b01 protects 0x2000..0x3FFF. 2'b10 protects 0x1000..0x3FFF. 2'b11 protects 0x0000..0x3FFF.
- R4: While the stored lock bit (bit 0) is 1, a register write is refused: `reg_ack_o` stays 0 and the four control bits never change again, including across `reload_i`.
- R5: The register layout is bit 3 enable, bit 2 block-select high, bit 1 block-select low, bit 0 lock. Bits 7..4 of a written value are discarded, and those bits always read as 0.
- R6: Only address bits 13..0 take part in the range compare; bits 15..14 of `addr_i` have no effect on `prot_o`.
- R7: `wr_ok_o` is 1 only when `chk_i` is 1 and the address is not protected. A byte to a protected address gets no acknowledge.
- R8: A `reload_i` pulse copies the stored control bits into the active copy. It leaves the stored bits unchanged.
- R9: A register write with the lock clear is accepted in the same cycle (`reg_ack_o`=1). Its low four bits are readable on `reg_rdata_o` from the next cycle.
- R10: The active copy changes only on a clock edge where `txn_start_i` or `reload_i` is 1. In that case it takes the stored value from before any register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous cold reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write value |
| reg_ack_o | output | 1 | Register write accepted |
| reg_rdata_o | output | 8 | Stored register value |
| txn_start_i | input | 1 | Start of a write transaction; refreshes the active copy |
| reload_i | input | 1 | Soft reset; restores the active copy from the store |
| addr_i | input | 16 | Array address under check |
| chk_i | input | 1 | Data byte for `addr_i` is presented |
| prot_o | output | 1 | Address lies in the protected range |
| wr_ok_o | output | 1 | Data byte may be acknowledged and committed |

## Verification
A register update and the capture of the active copy can land on the same clock edge. This happens when `reg_wr_i` coincides with `txn_start_i` or with `reload_i`. The bench drives these pairs together on purpose. The reference model decides that the captured copy must hold the value stored before the write, and that the new value appears only after the next start or reload. The address sweep that follows each coincidence judges the outcome through `prot_o` and `wr_ok_o`.

// File: rtl/wp_pkg.sv
package wp_pkg;
  parameter int ADDR_W = 16;
  parameter int ARR_AW = 14;
  parameter int REG_W  = 8;
  parameter int SEG_W  = 2;
  localparam int CTRL_W = 4;

  // bit order matches the register layout: [3]=en [2:1]=bsel [0]=lock
  typedef struct packed {
    logic       en;
    logic [1:0] bsel;
    logic       lock;
  } wp_ctrl_t;
endpackage

// File: rtl/wp_store.sv
module wp_store
  import wp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     upd_i,
  input  wp_ctrl_t upd_data_i,
  input  logic     load_i,
  output wp_ctrl_t nv_o,
  output wp_ctrl_t act_o,
  output logic     upd_ok_o
);
  wp_ctrl_t nv_q, act_q;

  assign upd_ok_o = upd_i & ~nv_q.lock;

  // retained store: only a cold reset clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       nv_q <= '0;
    else if (upd_ok_o) nv_q <= upd_data_i;
  end

  // active copy samples the pre-update store value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '0;
    else if (load_i) act_q <= nv_q;
  end

  assign nv_o  = nv_q;
  assign act_o = act_q;

  AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_q.lock |=> $stable(nv_q)); // R4
  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_q)); // R10
endmodule

// File: rtl/wp_range.sv
module wp_range
  import wp_pkg::*;
#(
  parameter int AW = ARR_AW,
  parameter int SW = SEG_W
) (
  input  wp_ctrl_t      ctrl_i,
  input  logic [AW-1:0] addr_i,
  output logic          prot_o
);
  localparam logic [SW-1:0] SEG_TOP = {SW{1'b1}};

  logic [SW-1:0] seg, thr;

  // protected region starts at segment (top - bsel)
  assign seg    = addr_i[AW-1 -: SW];
  assign thr    = SEG_TOP - ctrl_i.bsel;
  assign prot_o = ctrl_i.en && (seg >= thr);
endmodule

// File: rtl/wp_unit.sv
module wp_unit
  import wp_pkg::*;
#(
  parameter int AW_BUS = ADDR_W,
  parameter int AW_ARR = ARR_AW,
  parameter int RW     = REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [RW-1:0]     reg_wdata_i,
  output logic              reg_ack_o,
  output logic [RW-1:0]     reg_rdata_o,
  input  logic              txn_start_i,
  input  logic              reload_i,
  input  logic [AW_BUS-1:0] addr_i,
  input  logic              chk_i,
  output logic              prot_o,
  output logic              wr_ok_o
);
  localparam int PAD_W = RW - CTRL_W;

  wp_ctrl_t nv, act, wdat;
  logic     prot;

  assign wdat = wp_ctrl_t'(reg_wdata_i[CTRL_W-1:0]);

  wp_store u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (reg_wr_i),
    .upd_data_i(wdat),
    .load_i    (txn_start_i | reload_i),
    .nv_o      (nv),
    .act_o     (act),
    .upd_ok_o  (reg_ack_o)
  );

  wp_range #(.AW(AW_ARR), .SW(SEG_W)) u_range (
    .ctrl_i(act),
    .addr_i(addr_i[AW_ARR-1:0]),
    .prot_o(prot)
  );

  assign prot_o      = prot;
  assign wr_ok_o     = chk_i & ~prot;
  assign reg_rdata_o = {{PAD_W{1'b0}}, nv};

  AST_OPEN_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act.en |-> !prot_o); // R2
  AST_FULL_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act.en && act.bsel == 2'b11) |-> prot_o); // R3
  AST_TOP_SEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act.en && addr_i[AW_ARR-1 -: 2] == 2'b11) |-> prot_o); // R3
  AST_UPD_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_ack_o |=> reg_rdata_o == {{PAD_W{1'b0}}, $past(reg_wdata_i[CTRL_W-1:0])}); // R9
  AST_NO_ACK_PROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_i && act.en && act.bsel == 2'b11) |-> !wr_ok_o); // R7
endmodule

// File: tb/sim_wp_unit.sv
module sim_wp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_ack;
  logic [7:0]  reg_rdata;
  logic        txn_start = 1'b0;
  logic        reload = 1'b0;
  logic [15:0] addr = '0;
  logic        chk = 1'b0;
  logic        prot;
  logic        wr_ok;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int m_nv = 0;
  int m_act = 0;

  always #2 clk = ~clk;

  wp_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_ack_o(reg_ack), .reg_rdata_o(reg_rdata), .txn_start_i(txn_start),
    .reload_i(reload), .addr_i(addr), .chk_i(chk), .prot_o(prot), .wr_ok_o(wr_ok)
  );

  task automatic cyc(input bit wr, input int wd, input bit st, input bit rl,
                     input int a, input bit ck, input string tag);
    int en, bs, seg;
    bit e_prot, e_ack, e_ok;
    int e_rd, nxt_act;
    @(negedge clk);
    reg_wr = wr; reg_wdata = wd[7:0]; txn_start = st; reload = rl;
    addr = a[15:0]; chk = ck;
    #1;
    en  = (m_act >> 3) & 1;
    bs  = (m_act >> 1) & 3;
    seg = (a >> 12) & 3;
    e_prot = (en == 1) && (seg >= 3 - bs);
    e_ack  = wr && ((m_nv & 1) == 0);
    e_ok   = ck && !e_prot;
    e_rd   = m_nv;
    checks++;
    if (prot !== e_prot || reg_ack !== e_ack || wr_ok !== e_ok || reg_rdata !== e_rd[7:0]) begin
      errors++;
      $display("FAIL %s: addr=%h prot=%b/%b ack=%b/%b ok=%b/%b rdata=%h/%h (actual/expected)",
               tag, a[15:0], prot, e_prot, reg_ack, e_ack, wr_ok, e_ok, reg_rdata, e_rd[7:0]);
    end
    nxt_act = (st || rl) ? m_nv : m_act;
    if (e_ack) m_nv = wd & 15;
    m_act = nxt_act;
  endtask

  task automatic sweep(input string tag);
    int pts[9] = '{16'h0000, 16'h0FFF, 16'h1000, 16'h1FFF, 16'h2000,
                   16'h2FFF, 16'h3000, 16'h3FFF, 16'h2A55};
    foreach (pts[i]) cyc(0, 0, 0, 0, pts[i], 1, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cyc(0, 0, 0, 0, 16'h3FFF, 1, "R1");
    cyc(0, 0, 0, 0, 16'h0000, 1, "R1");
    // R5 upper bits dropped; R9 accepted, readable next cycle
    cyc(1, 8'hF8, 0, 0, 16'h3000, 1, "R5");
    cyc(0, 0, 0, 0, 16'h3000, 1, "R9");
    // R10 not in effect until a start
    cyc(0, 0, 0, 0, 16'h3FFF, 1, "R10");
    cyc(0, 0, 1, 0, 16'h3FFF, 1, "R10");
    sweep("R3");
    // R6 high address bits ignored
    cyc(0, 0, 0, 0, 16'hC000, 1, "R6");
    cyc(0, 0, 0, 0, 16'hF000, 1, "R6");
    cyc(0, 0, 0, 0, 16'h4FFF, 1, "R6");
    for (int b = 1; b < 4; b++) begin
      cyc(1, 8 | (b << 1), 0, 0, 16'h0000, 0, "R9");
      cyc(0, 0, 1, 0, 16'h0000, 1, "R3");
      sweep("R3");
      cyc(0, 0, 0, 0, 16'h8FFF, 1, "R6");
    end
    // R2 disabled with full block select
    cyc(1, 8'h06, 0, 0, 16'h0000, 1, "R2");
    cyc(0, 0, 1, 0, 16'h0000, 1, "R2");
    sweep("R2");
    // R10 coincident write and start: old value captured
    cyc(1, 8'h0E, 1, 0, 16'h3FFF, 1, "R10");
    cyc(0, 0, 0, 0, 16'h3FFF, 1, "R10");
    cyc(0, 0, 1, 0, 16'h3FFF, 1, "R10");
    sweep("R7");
    // R8 reload restores active copy; store unchanged
    cyc(1, 8'h08, 0, 0, 16'h0000, 1, "R8");
    cyc(0, 0, 0, 1, 16'h0000, 1, "R8");
    cyc(0, 0, 0, 0, 16'h0000, 1, "R8");
    cyc(0, 0, 0, 0, 16'h3000, 1, "R8");
    // R10 coincident write and reload
    cyc(1, 8'h0C, 0, 1, 16'h1000, 1, "R10");
    cyc(0, 0, 0, 0, 16'h1000, 1, "R10");
    cyc(0, 0, 0, 1, 16'h1000, 1, "R10");
    // R4 lock then refused updates
    cyc(1, 8'h0B, 0, 0, 16'h0000, 1, "R4");
    cyc(1, 8'h00, 0, 0, 16'h0000, 1, "R4");
    cyc(1, 8'hF0, 1, 0, 16'h0000, 1, "R4");
    sweep("R4");
    cyc(0, 0, 0, 1, 16'h0000, 1, "R4");
    cyc(1, 8'h08, 0, 1, 16'h0FFF, 1, "R4");
    sweep("R4");
    // R7 no check strobe, no ok
    cyc(0, 0, 0, 0, 16'h3000, 0, "R7");
    cyc(0, 0, 0, 0, 16'h0800, 0, "R7");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule